// File: doc/BRIEF.md
# Multi-Port Link Hold-Off Controller

This block keeps the ports of a multi-port Ethernet transceiver from bringing up a link until management software has configured them. It holds one control register per port. Bit 11 of that register is the power-down bit: while it is set, the port's transmit and receive analog enables are low, so the port cannot form a link or pass packets. Register access and loopback control keep working on a held port.

A hold-off strap is sampled once after hardware reset. When the strap is high, every port starts held. Software then releases each port with its own write, and may hold any port again at any time. A software reset of one port reloads that port's register from its defaults. In those defaults the power-down bit is the strap value captured at the last hardware reset, so a strapped system can put one port back into hold-off without a chip-wide reset. A management-disable input turns the whole feature off. A part with no management access must never start held, because nothing could release it.

A simple write strobe and a combinational read path stand in for the management interface. Port addresses are 3 bits, register addresses are 5 bits and data is 16 bits. Only register 0 is implemented.

Top module: `link_holdoff_ctrl`

## Requirements
- R1: On the first clock edge after `rst_n` deasserts, the block captures `strap_hold_i` (masked by `mgmt_dis_i`). From then on, register 0 of every port has bit 11 equal to the captured value and every other bit 0.
- R2: While a port's register 0 bit 11 is 1 and `mgmt_dis_i` is 0, `hold_o` for that port is 1 and `tx_en_o` and `rx_en_o` for that port are 0. Otherwise `hold_o` is 0 and both enables are 1.
- R3: A write of data with bit 11 = 0 and bit 15 = 0 to register 0 of one port releases that port on the next cycle. The hold, enables and register contents of every other port are unchanged.
- R4: Software can set or clear bit 11 of any port at any time, whatever the strap value was. A write of data with bit 15 = 0 stores bits 14:0 as written.
- R5: A write to register 0 with bit 15 = 1 reloads that port's register with its defaults (bit 11 = captured strap, all other bits 0) and ignores the other data bits. Other ports are unchanged. The internal reset-pending flag clears on the following cycle.
- R6: While `mgmt_dis_i` is 1, all `hold_o` are 0, all enables are 1 and register writes are ignored. A strap captured while `mgmt_dis_i` is 1 counts as 0.
- R7: `lpbk_o` of a port equals bit 14 of its register 0, whether or not the port is held.
- R8: `rd_data_o` returns register 0 of the addressed port, with bit 15 always reading 0. It returns 0 for any other register address and for port addresses at or above `NPORT`. Writes to such addresses change nothing.
- R9: Changes of `strap_hold_i` after the capture edge have no effect until the next hardware reset. This includes the default reloaded by a software reset.
- R10: While `rst_n` is low and `mgmt_dis_i` is 0, every port is held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low, asynchronous assert |
| strap_hold_i | input | 1 | Hold-off strap, captured after reset |
| mgmt_dis_i | input | 1 | Management disable; turns hold-off off |
| wr_en_i | input | 1 | One-cycle register write strobe |
| port_addr_i | input | PA_W | Port address for read and write |
| reg_addr_i | input | RA_W | Register address for read and write |
| wr_data_i | input | 16 | Write data |
| rd_data_o | output | 16 | Read data for the addressed port and register |
| hold_o | output | NPORT | Per-port hold status |
| tx_en_o | output | NPORT | Per-port transmit analog enable |
| rx_en_o | output | NPORT | Per-port receive analog enable |
| lpbk_o | output | NPORT | Per-port internal loopback enable |

## Verification
The bench builds the block with `NPORT = 6` and the default 3-bit port address. This leaves addresses 6 and 7 decodable but unimplemented, so the out-of-range cases of R8 are reachable. It sweeps all four combinations of strap and management-disable across a hardware reset. In each combination it releases, re-holds and software-resets every port in turn, and compares the hold, enable, loopback and read-back values of all six ports against a register model after every step.

// File: rtl/link_holdoff_ctrl.sv
module link_holdoff_ctrl #(
  parameter int NPORT = 8,
  parameter int PA_W  = 3,
  parameter int RA_W  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strap_hold_i,
  input  logic             mgmt_dis_i,
  input  logic             wr_en_i,
  input  logic [PA_W-1:0]  port_addr_i,
  input  logic [RA_W-1:0]  reg_addr_i,
  input  logic [15:0]      wr_data_i,
  output logic [15:0]      rd_data_o,
  output logic [NPORT-1:0] hold_o,
  output logic [NPORT-1:0] tx_en_o,
  output logic [NPORT-1:0] rx_en_o,
  output logic [NPORT-1:0] lpbk_o
);
  localparam int BIT_RST = 15;
  localparam int BIT_LB  = 14;
  localparam int BIT_PD  = 11;

  logic             cap_done_q;
  logic             strap_q;
  logic [15:0]      ctl_q [NPORT];
  logic [NPORT-1:0] pend_q;

  wire strap_eff = strap_hold_i & ~mgmt_dis_i;
  wire wr_ok     = wr_en_i && cap_done_q && !mgmt_dis_i && (reg_addr_i == '0);
  wire [15:0] dflt_now = 16'(strap_eff) << BIT_PD;
  wire [15:0] dflt_cap = 16'(strap_q) << BIT_PD;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_done_q <= 1'b0;
      strap_q    <= 1'b0;
    end else if (!cap_done_q) begin
      cap_done_q <= 1'b1;
      strap_q    <= strap_eff;
    end
  end

  for (genvar i = 0; i < NPORT; i++) begin : g_port
    wire hit = wr_ok && (32'(port_addr_i) == i);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ctl_q[i]  <= '0;
        pend_q[i] <= 1'b0;
      end else if (!cap_done_q) begin
        ctl_q[i]  <= dflt_now;
        pend_q[i] <= 1'b0;
      end else begin
        pend_q[i] <= 1'b0;
        if (hit) begin
          if (wr_data_i[BIT_RST]) begin
            ctl_q[i]  <= dflt_cap;
            pend_q[i] <= 1'b1;
          end else begin
            ctl_q[i]  <= {1'b0, wr_data_i[14:0]};
          end
        end
      end
    end

    assign hold_o[i]  = !mgmt_dis_i && (!cap_done_q || ctl_q[i][BIT_PD]);
    assign tx_en_o[i] = !hold_o[i];
    assign rx_en_o[i] = !hold_o[i];
    assign lpbk_o[i]  = ctl_q[i][BIT_LB];
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NPORT; i++)
      if (32'(port_addr_i) == i && reg_addr_i == '0)
        rd_data_o = ctl_q[i] & 16'h7FFF;
  end
endmodule

// File: rtl/link_holdoff_chk.sv
module link_holdoff_chk #(
  parameter int NPORT = 8,
  parameter int PA_W  = 3,
  parameter int RA_W  = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mgmt_dis_i,
  input logic             wr_en_i,
  input logic [PA_W-1:0]  port_addr_i,
  input logic [RA_W-1:0]  reg_addr_i,
  input logic [15:0]      wr_data_i,
  input logic [15:0]      rd_data_o,
  input logic [NPORT-1:0] hold_o,
  input logic [NPORT-1:0] tx_en_o,
  input logic [NPORT-1:0] rx_en_o,
  input logic [NPORT-1:0] pend_q,
  input logic             cap_done_q,
  input logic             strap_q
);
  logic [NPORT-1:0] any_m, clr_m, set_m, any_mq, clr_mq, set_mq;

  always_comb begin
    any_m = '0;
    for (int i = 0; i < NPORT; i++)
      if (wr_en_i && cap_done_q && !mgmt_dis_i && reg_addr_i == '0 && 32'(port_addr_i) == i)
        any_m[i] = 1'b1;
    clr_m = (wr_data_i[15] || wr_data_i[11]) ? '0 : any_m;
    set_m = (!wr_data_i[15] && wr_data_i[11]) ? any_m : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      any_mq <= '0;
      clr_mq <= '0;
      set_mq <= '0;
    end else begin
      any_mq <= any_m;
      clr_mq <= clr_m;
      set_mq <= set_m;
    end
  end

  assert_rd_msb_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data_o[15] == 1'b0);

  assert_mgmt_dis_open_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mgmt_dis_i |-> (&tx_en_o && &rx_en_o && hold_o == '0));

  assert_release_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_mq) |-> ((clr_mq & hold_o) == '0));

  assert_set_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_mq && !mgmt_dis_i) |-> ((set_mq & hold_o) == set_mq));

  assert_others_untouched_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|any_mq && $stable(mgmt_dis_i)) |-> (((hold_o ^ $past(hold_o)) & ~any_mq) == '0));

  assert_strap_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cap_done_q |=> $stable(strap_q));

  for (genvar i = 0; i < NPORT; i++) begin : g_p
    assert_swrst_selfclear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q[i] && !(any_m[i] && wr_data_i[15])) |=> !pend_q[i]);
  end
endmodule

bind link_holdoff_ctrl link_holdoff_chk #(.NPORT(NPORT), .PA_W(PA_W), .RA_W(RA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mgmt_dis_i(mgmt_dis_i), .wr_en_i(wr_en_i),
  .port_addr_i(port_addr_i), .reg_addr_i(reg_addr_i), .wr_data_i(wr_data_i),
  .rd_data_o(rd_data_o), .hold_o(hold_o), .tx_en_o(tx_en_o), .rx_en_o(rx_en_o),
  .pend_q(pend_q), .cap_done_q(cap_done_q), .strap_q(strap_q)
);

// File: tb/tb_link_holdoff_ctrl.sv
`timescale 1ns/1ps
module tb_link_holdoff_ctrl;
  localparam int NPORT = 6;
  localparam int PA_W  = 3;
  localparam int RA_W  = 5;

  logic clk = 1'b0, rst_n = 1'b0, strap = 1'b0, mdis = 1'b0, wr_en = 1'b0;
  logic [PA_W-1:0] pa = '0;
  logic [RA_W-1:0] ra = '0;
  logic [15:0] wd = '0, rd;
  logic [NPORT-1:0] hold, txe, rxe, lpbk;

  int checks = 0, fails = 0;
  logic [15:0] exp_reg [NPORT];
  logic exp_strap;

  always #2.5 clk = ~clk;

  link_holdoff_ctrl #(.NPORT(NPORT), .PA_W(PA_W), .RA_W(RA_W)) dut (
    .clk(clk), .rst_n(rst_n), .strap_hold_i(strap), .mgmt_dis_i(mdis),
    .wr_en_i(wr_en), .port_addr_i(pa), .reg_addr_i(ra), .wr_data_i(wd),
    .rd_data_o(rd), .hold_o(hold), .tx_en_o(txe), .rx_en_o(rxe), .lpbk_o(lpbk));

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int p, input int r, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; pa = PA_W'(p); ra = RA_W'(r); wd = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic check_all(input string req);
    for (int p = 0; p < NPORT; p++) begin
      bit eh;
      eh = !mdis && exp_reg[p][11];
      chk(hold[p] == eh, {req, " R2 hold"}, 16'(hold[p]), 16'(eh));
      chk(txe[p] == !eh && rxe[p] == !eh, {req, " R2 enables"}, 16'({txe[p], rxe[p]}), 16'({!eh, !eh}));
      chk(lpbk[p] == exp_reg[p][14], {req, " R7 loopback"}, 16'(lpbk[p]), 16'(exp_reg[p][14]));
      pa = PA_W'(p); ra = '0;
      #0.2;
      chk(rd === exp_reg[p], {req, " R8 read"}, rd, exp_reg[p]);
    end
  endtask

  task automatic hw_reset(input logic s, input logic m);
    @(negedge clk);
    rst_n = 1'b0; strap = s; mdis = m;
    repeat (3) @(negedge clk);
    chk(hold == (m ? '0 : {NPORT{1'b1}}), "R10 hold in reset", 16'(hold), 16'(m ? 0 : (1 << NPORT) - 1));
    rst_n = 1'b1;
    @(negedge clk);
    exp_strap = s & ~m;
    for (int p = 0; p < NPORT; p++) exp_reg[p] = 16'(exp_strap) << 11;
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int s = 0; s < 2; s++) begin
      for (int m = 0; m < 2; m++) begin
        hw_reset(s[0], m[0]);
        check_all("R1 after capture");
        if (m == 1) begin
          wr(0, 0, 16'h0800);
          wr(1, 0, 16'h4000);
          mdis = 1'b0;
          #0.2;
          check_all("R6 writes ignored");
        end
        for (int p = 0; p < NPORT; p++) begin
          logic [15:0] d;
          d = 16'h0123 ^ 16'(p << 2);
          wr(p, 0, d);
          exp_reg[p] = d;
          check_all("R3 release one");
        end
        for (int p = 0; p < NPORT; p++) begin
          logic [15:0] d;
          d = 16'h4800 | 16'(p);
          wr(p, 0, d);
          exp_reg[p] = d;
          check_all("R4 set hold");
        end
        wr(2, 0, 16'h4000);
        exp_reg[2] = 16'h4000;
        check_all("R4 clear with loopback");
        for (int a = 0; a < 8; a++) begin
          wr(a, 1, 16'hFFFF);
          wr(a, 31, 16'h8000);
        end
        wr(6, 0, 16'h0000);
        wr(7, 0, 16'h8000);
        check_all("R8 ignored writes");
        for (int a = 0; a < 8; a++) begin
          @(negedge clk);
          pa = PA_W'(a); ra = 5'd1;
          #0.2;
          chk(rd == 16'h0, "R8 other register reads 0", rd, 16'h0);
          if (a >= NPORT) begin
            ra = '0;
            #0.2;
            chk(rd == 16'h0, "R8 out-of-range port reads 0", rd, 16'h0);
          end
        end
        strap = ~s[0];
        for (int p = 0; p < NPORT; p++) begin
          wr(p, 0, 16'hC7FF);
          exp_reg[p] = 16'(exp_strap) << 11;
          check_all("R5 R9 soft reset");
        end
        wr(3, 0, 16'h0000);
        exp_reg[3] = 16'h0000;
        wr(3, 0, 16'h8000);
        exp_reg[3] = 16'(exp_strap) << 11;
        check_all("R5 re-hold after release");
      end
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule